// File: doc/BRIEF.md
# 1000BASE-X Auto-Negotiation Controller

This block negotiates the link configuration of a gigabit fiber or SerDes link by exchanging 16-bit configuration words with the link partner. A separate framing layer carries these words in the third and fourth symbols of each /C/ ordered set. The block builds the word to transmit from a software-set base page and one optional next page. It filters the partner's words for consistency and handles the acknowledge handshake. It then waits out a link timer and a run of idles, and resolves duplex and pause enables from both sides' abilities. Once negotiation completes, the resolved duplex and pause values take precedence over the values software configured.

When negotiation is disabled, a force-link request raises link-up directly. It does so only while the receiver reports signal presence. Negotiation is restarted by a fixed set of trigger events. A partner word of all zeros, which signals a link break, also restarts it.

Top module: `lx_autoneg`

## Requirements
- R1: After a synchronous reset, tx_cfg_valid, tx_cfg, lp_base, lp_np, link_up, full_duplex, tx_pause, rx_pause and an_fail are all 0.
- R2: A restart trigger sends all-zero config words (tx_cfg_valid=1, tx_cfg=0) and drops link_up. The triggers are link_rst falling, an_en rising and an_restart rising. After LINK_TIMER+1 cycles of zeros, the base page is sent.
- R3: The transmitted base page is adv_base with bits 11:9 and 4:0 forced to 0. Bit 14 (acknowledge) is set only after the partner's word has been matched.
- R4: A partner word is matched after MATCH_N consecutive identical words, compared with bit 14 ignored. A matched all-zero word is never accepted. The matched word is stored in lp_base with bit 14 cleared.
- R5: After MATCH_N consecutive identical partner words carrying bit 14, the block keeps sending the acknowledged page for LINK_TIMER cycles. It then sends idles (tx_cfg_valid=0), and raises link_up once IDLE_N consecutive idles have been received.
- R6: When bit 15 (next page) is set in both adv_base and lp_base, a second exchange sends adv_np after the base page completes. The partner's matched next word is stored in lp_np with bit 14 cleared. If either side's bit 15 is clear, adv_np is never sent.
- R7: full_duplex is 1 when both sides set bit 5. Half duplex (link_up=1, full_duplex=0) is chosen when both sides set bit 6 but not both bit 5. With neither in common, an_fail is 1 and link_up stays 0.
- R8: Pause uses bit 7 (symmetric) and bit 8 (asymmetric). Both symmetric gives tx_pause=rx_pause=1. Local sym+asym against partner asym-only gives rx_pause only. Local asym-only against partner sym+asym gives tx_pause only. Any other combination gives neither.
- R9: A config word received while link_up is 1 drops link_up and restarts negotiation.
- R10: An all-zero received word during acknowledge or complete-acknowledge restarts negotiation.
- R11: During acknowledge, a matched partner word that differs from the stored page (bit 14 ignored) restarts negotiation.
- R12: While an_en=1, link_rst=1 or sync_ok=0 holds the block in restart, sending zeros with link_up=0. The return of sync renegotiates.
- R13: With an_en=0, link_up follows force_link while los=0 or rx_energy=1. With an_en=1, force_link has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_base | input | 16 | Local base page to advertise |
| adv_np | input | 16 | Local next page to send |
| an_en | input | 1 | Negotiation enable |
| an_restart | input | 1 | Restart request, rising edge acts |
| link_rst | input | 1 | Link reset, holds restart, falling edge restarts |
| force_link | input | 1 | Force link up when negotiation is disabled |
| rx_cfg_valid | input | 1 | A config word was received this cycle |
| rx_cfg | input | 16 | Received config word |
| rx_idle | input | 1 | An idle was received this cycle |
| sync_ok | input | 1 | Receiver is synchronized |
| los | input | 1 | Loss of signal |
| rx_energy | input | 1 | Receive energy present |
| tx_cfg_valid | output | 1 | Send config words (1) or idles (0) |
| tx_cfg | output | 16 | Config word to send |
| lp_base | output | 16 | Partner base page |
| lp_np | output | 16 | Partner next page |
| link_up | output | 1 | Link is up |
| full_duplex | output | 1 | Resolved full duplex |
| tx_pause | output | 1 | Resolved pause transmit enable |
| rx_pause | output | 1 | Resolved pause receive enable |
| an_fail | output | 1 | No common duplex mode |

## Verification
The assertions check on every cycle that link reset, lost sync and a restart edge force zero words and drop link-up. They also check that a zero word during acknowledge restarts the exchange, that a config word kills an up link, and that force-link obeys signal presence. Resolved duplex, pause and failure are checked to appear only together with a consistent link state. Only the bench scenarios can show the content of the exchange: the base-page masking, the match-and-acknowledge order, the next-page sequence, the stored partner pages, and each row of the duplex and pause resolution.

// File: rtl/lx_an_pkg.sv
package lx_an_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_BREAK, ST_ABIL, ST_ACK, ST_CPL, ST_IDLE, ST_UP, ST_FAIL
  } an_state_t;

  localparam int unsigned CW_W  = 16;
  localparam int unsigned B_NP  = 15;
  localparam int unsigned B_ACK = 14;
  // bits kept in a transmitted base page: NP, ACK, RF, pause pair, HD, FD
  localparam logic [CW_W-1:0] BASE_KEEP = 16'hF1E0;
  localparam logic [CW_W-1:0] NO_ACK    = 16'hBFFF;
endpackage

// File: rtl/lx_an_rxmatch.sv
module lx_an_rxmatch #(
  parameter int unsigned MATCH_N = 3,
  parameter int unsigned IDLE_N  = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [15:0] rx_word,
  input  logic        rx_idle,
  output logic        ab_match,
  output logic        ack_match,
  output logic        idle_match,
  output logic [15:0] word
);
  import lx_an_pkg::*;
  localparam int unsigned CW = $clog2(MATCH_N + 1);
  localparam int unsigned IW = $clog2(IDLE_N + 1);
  localparam logic [CW-1:0] M_LIM = CW'(MATCH_N);
  localparam logic [IW-1:0] I_LIM = IW'(IDLE_N);

  logic [CW-1:0] same_cnt, ack_cnt;
  logic [IW-1:0] idle_cnt;
  logic          same_word, ack_run;

  assign same_word = (same_cnt != '0) && ((rx_word & NO_ACK) == (word & NO_ACK));
  assign ack_run   = (ack_cnt != '0) && (rx_word == word);

  always_ff @(posedge clk) begin
    if (rst) begin
      same_cnt <= '0;
      ack_cnt  <= '0;
      idle_cnt <= '0;
      word     <= '0;
    end else if (rx_valid) begin
      word     <= rx_word;
      idle_cnt <= '0;
      if (same_word) same_cnt <= (same_cnt == M_LIM) ? same_cnt : same_cnt + 1'b1;
      else           same_cnt <= CW'(1);
      if (!rx_word[B_ACK]) ack_cnt <= '0;
      else if (ack_run)    ack_cnt <= (ack_cnt == M_LIM) ? ack_cnt : ack_cnt + 1'b1;
      else                 ack_cnt <= CW'(1);
    end else begin
      same_cnt <= '0;
      ack_cnt  <= '0;
      if (rx_idle) idle_cnt <= (idle_cnt == I_LIM) ? idle_cnt : idle_cnt + 1'b1;
      else         idle_cnt <= '0;
    end
  end

  assign ab_match   = (same_cnt == M_LIM);
  assign ack_match  = (ack_cnt == M_LIM);
  assign idle_match = (idle_cnt == I_LIM);
endmodule

// File: rtl/lx_an_timer.sv
module lx_an_timer #(
  parameter int unsigned LIMIT = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)     cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/lx_an_resolve.sv
module lx_an_resolve (
  input  logic [3:0] loc,  // {asym, sym, hd, fd}
  input  logic [3:0] lp,
  output logic       fd,
  output logic       dup_ok,
  output logic       tx_p,
  output logic       rx_p
);
  logic both_sym;
  assign fd       = loc[0] & lp[0];
  assign dup_ok   = fd | (loc[1] & lp[1]);
  assign both_sym = loc[2] & lp[2];
  assign tx_p     = both_sym | (!loc[2] & loc[3] & lp[2] & lp[3]);
  assign rx_p     = both_sym | (loc[2] & loc[3] & !lp[2] & lp[3]);
endmodule

// File: rtl/lx_autoneg.sv
module lx_autoneg #(
  parameter int unsigned LINK_TIMER = 1250000,
  parameter int unsigned MATCH_N    = 3,
  parameter int unsigned IDLE_N     = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] adv_base,
  input  logic [15:0] adv_np,
  input  logic        an_en,
  input  logic        an_restart,
  input  logic        link_rst,
  input  logic        force_link,
  input  logic        rx_cfg_valid,
  input  logic [15:0] rx_cfg,
  input  logic        rx_idle,
  input  logic        sync_ok,
  input  logic        los,
  input  logic        rx_energy,
  output logic        tx_cfg_valid,
  output logic [15:0] tx_cfg,
  output logic [15:0] lp_base,
  output logic [15:0] lp_np,
  output logic        link_up,
  output logic        full_duplex,
  output logic        tx_pause,
  output logic        rx_pause,
  output logic        an_fail
);
  import lx_an_pkg::*;

  an_state_t   state, nxt;
  logic        np_phase, np_nxt;
  logic        lrst_q, en_q, rs_q, sync_q, trig, hold;
  logic        ab_match, ack_match, idle_match, tmr_done, tmr_clr;
  logic [15:0] mword, ref_page, page;
  logic        zero_rx, changed;
  logic        r_fd, r_ok, r_txp, r_rxp;

  lx_an_rxmatch #(.MATCH_N(MATCH_N), .IDLE_N(IDLE_N)) u_match (
    .clk(clk), .rst(rst), .rx_valid(rx_cfg_valid), .rx_word(rx_cfg),
    .rx_idle(rx_idle), .ab_match(ab_match), .ack_match(ack_match),
    .idle_match(idle_match), .word(mword));

  lx_an_timer #(.LIMIT(LINK_TIMER)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .done(tmr_done));

  lx_an_resolve u_res (
    .loc(adv_base[8:5]), .lp(lp_base[8:5]),
    .fd(r_fd), .dup_ok(r_ok), .tx_p(r_txp), .rx_p(r_rxp));

  always_ff @(posedge clk) begin
    if (rst) begin
      lrst_q <= 1'b0; en_q <= 1'b0; rs_q <= 1'b0; sync_q <= 1'b0;
    end else begin
      lrst_q <= link_rst; en_q <= an_en; rs_q <= an_restart; sync_q <= sync_ok;
    end
  end

  assign trig     = (lrst_q && !link_rst) || (an_en && !en_q) ||
                    (an_restart && !rs_q) || (sync_ok && !sync_q);
  assign hold     = link_rst || !sync_ok;
  assign zero_rx  = rx_cfg_valid && (rx_cfg == 16'h0);
  assign ref_page = np_phase ? lp_np : lp_base;
  assign changed  = ab_match && ((mword & NO_ACK) != ref_page);

  always_comb begin
    nxt = state;
    if (!an_en)            nxt = ST_OFF;
    else if (hold || trig) nxt = ST_BREAK;
    else begin
      case (state)
        ST_OFF:   nxt = ST_BREAK;
        ST_BREAK: if (tmr_done) nxt = ST_ABIL;
        ST_ABIL:  if (ab_match && ((mword & NO_ACK) != 16'h0) &&
                      (!np_phase || ((mword & NO_ACK) != lp_base))) nxt = ST_ACK;
        ST_ACK: begin
          if (zero_rx || changed) nxt = ST_BREAK;
          else if (ack_match && ((mword & NO_ACK) == ref_page)) nxt = ST_CPL;
        end
        ST_CPL: begin
          if (zero_rx || changed) nxt = ST_BREAK;
          else if (tmr_done)
            nxt = (!np_phase && adv_base[B_NP] && lp_base[B_NP]) ? ST_ABIL : ST_IDLE;
        end
        ST_IDLE: begin
          if (zero_rx) nxt = ST_BREAK;
          else if (tmr_done && idle_match) nxt = r_ok ? ST_UP : ST_FAIL;
        end
        ST_UP, ST_FAIL: if (rx_cfg_valid) nxt = ST_BREAK;
        default: nxt = ST_BREAK;
      endcase
    end
  end

  always_comb begin
    if (nxt == ST_OFF || nxt == ST_BREAK)      np_nxt = 1'b0;
    else if (state == ST_CPL && nxt == ST_ABIL) np_nxt = 1'b1;
    else                                        np_nxt = np_phase;
  end

  assign tmr_clr = (nxt != state) || (nxt == ST_BREAK && (hold || trig));

  always_comb begin
    page = np_nxt ? adv_np : (adv_base & BASE_KEEP);
    page[B_ACK] = (nxt == ST_ACK) || (nxt == ST_CPL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_OFF;
      np_phase     <= 1'b0;
      lp_base      <= '0;
      lp_np        <= '0;
      tx_cfg_valid <= 1'b0;
      tx_cfg       <= '0;
      link_up      <= 1'b0;
      full_duplex  <= 1'b0;
      tx_pause     <= 1'b0;
      rx_pause     <= 1'b0;
      an_fail      <= 1'b0;
    end else begin
      state    <= nxt;
      np_phase <= np_nxt;
      if (state == ST_ABIL && nxt == ST_ACK) begin
        if (np_phase) lp_np   <= mword & NO_ACK;
        else          lp_base <= mword & NO_ACK;
      end
      tx_cfg_valid <= (nxt == ST_BREAK) || (nxt == ST_ABIL) ||
                      (nxt == ST_ACK) || (nxt == ST_CPL);
      tx_cfg       <= (nxt == ST_ABIL || nxt == ST_ACK || nxt == ST_CPL) ? page : 16'h0;
      link_up      <= (nxt == ST_UP) ||
                      (nxt == ST_OFF && force_link && (!los || rx_energy));
      full_duplex  <= (nxt == ST_UP) && r_fd;
      tx_pause     <= (nxt == ST_UP) && r_txp;
      rx_pause     <= (nxt == ST_UP) && r_rxp;
      an_fail      <= (nxt == ST_FAIL);
    end
  end
endmodule

// File: rtl/lx_an_chk.sv
module lx_an_chk (
  input logic        clk,
  input logic        rst,
  input logic        an_en,
  input logic        an_restart,
  input logic        link_rst,
  input logic        sync_ok,
  input logic        force_link,
  input logic        los,
  input logic        rx_energy,
  input logic        rx_cfg_valid,
  input logic [15:0] rx_cfg,
  input logic        tx_cfg_valid,
  input logic [15:0] tx_cfg,
  input logic        link_up,
  input logic        full_duplex,
  input logic        tx_pause,
  input logic        rx_pause,
  input logic        an_fail
);
  logic restart_q;
  always_ff @(posedge clk) begin
    if (rst) restart_q <= 1'b0;
    else     restart_q <= an_restart;
  end

  a_r2_restart_break: assert property (@(posedge clk) disable iff (rst)
    (an_en && an_restart && !restart_q) |=> (tx_cfg_valid && tx_cfg == 16'h0 && !link_up));

  a_r12_lrst_hold: assert property (@(posedge clk) disable iff (rst)
    (an_en && link_rst) |=> (tx_cfg_valid && tx_cfg == 16'h0 && !link_up));

  a_r12_sync_hold: assert property (@(posedge clk) disable iff (rst)
    (an_en && !sync_ok) |=> (tx_cfg_valid && tx_cfg == 16'h0 && !link_up));

  a_r9_cfg_kills_link: assert property (@(posedge clk) disable iff (rst)
    (an_en && link_up && rx_cfg_valid) |=> !link_up);

  a_r10_zero_restart: assert property (@(posedge clk) disable iff (rst)
    (an_en && tx_cfg_valid && tx_cfg[14] && rx_cfg_valid && rx_cfg == 16'h0)
      |=> (tx_cfg_valid && tx_cfg == 16'h0));

  a_r13_force_no_signal: assert property (@(posedge clk) disable iff (rst)
    (!an_en && los && !rx_energy) |=> !link_up);

  a_r13_force_up: assert property (@(posedge clk) disable iff (rst)
    (!an_en && force_link && !los) |=> link_up);

  a_r7_fd_needs_link: assert property (@(posedge clk) disable iff (rst)
    full_duplex |-> (link_up && !an_fail));

  a_r7_fail_excl: assert property (@(posedge clk) disable iff (rst)
    an_fail |-> (!link_up && !tx_cfg_valid));

  a_r8_pause_needs_link: assert property (@(posedge clk) disable iff (rst)
    (tx_pause || rx_pause) |-> link_up);
endmodule

bind lx_autoneg lx_an_chk u_chk (
  .clk(clk), .rst(rst), .an_en(an_en), .an_restart(an_restart),
  .link_rst(link_rst), .sync_ok(sync_ok), .force_link(force_link),
  .los(los), .rx_energy(rx_energy), .rx_cfg_valid(rx_cfg_valid),
  .rx_cfg(rx_cfg), .tx_cfg_valid(tx_cfg_valid), .tx_cfg(tx_cfg),
  .link_up(link_up), .full_duplex(full_duplex), .tx_pause(tx_pause),
  .rx_pause(rx_pause), .an_fail(an_fail));

// File: tb/lx_autoneg_bench.sv
`timescale 1ns/1ps
module lx_autoneg_bench;
  localparam int LT = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] adv_base = 16'h0FBF, adv_np = 16'h2123;
  logic        an_en = 0, an_restart = 0, link_rst = 0, force_link = 0;
  logic        rx_cfg_valid, rx_idle;
  logic [15:0] rx_cfg;
  logic        sync_ok = 1, los = 0, rx_energy = 0;
  logic        tx_cfg_valid, link_up, full_duplex, tx_pause, rx_pause, an_fail;
  logic [15:0] tx_cfg, lp_base, lp_np;

  // partner model controls
  logic [15:0] pbase = 16'h80A0, pnp = 16'h0555;
  logic        ovr = 0, ovr_valid = 0;
  logic [15:0] ovr_word = 16'h0;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  lx_autoneg #(.LINK_TIMER(LT), .MATCH_N(3), .IDLE_N(3)) u_lx_autoneg (
    .clk(clk), .rst(rst), .adv_base(adv_base), .adv_np(adv_np), .an_en(an_en),
    .an_restart(an_restart), .link_rst(link_rst), .force_link(force_link),
    .rx_cfg_valid(rx_cfg_valid), .rx_cfg(rx_cfg), .rx_idle(rx_idle),
    .sync_ok(sync_ok), .los(los), .rx_energy(rx_energy),
    .tx_cfg_valid(tx_cfg_valid), .tx_cfg(tx_cfg), .lp_base(lp_base), .lp_np(lp_np),
    .link_up(link_up), .full_duplex(full_duplex), .tx_pause(tx_pause),
    .rx_pause(rx_pause), .an_fail(an_fail));

  // link partner: mirrors breaks and idles, acks after three equal words
  initial begin
    logic [15:0] p_last, w, word;
    int p_cnt;
    p_last = 0; p_cnt = 0;
    rx_cfg_valid = 0; rx_cfg = 0; rx_idle = 1;
    forever begin
      @(negedge clk);
      if (ovr) begin
        rx_cfg_valid = ovr_valid; rx_cfg = ovr_word; rx_idle = !ovr_valid; p_cnt = 0;
      end else if (!tx_cfg_valid) begin
        rx_cfg_valid = 0; rx_cfg = 0; rx_idle = 1; p_cnt = 0;
      end else if (tx_cfg == 16'h0) begin
        rx_cfg_valid = 1; rx_cfg = 0; rx_idle = 0; p_cnt = 0; p_last = 0;
      end else begin
        w = tx_cfg & 16'hBFFF;
        if (w == p_last) begin if (p_cnt < 3) p_cnt++; end
        else p_cnt = 1;
        p_last = w;
        word = (w == (adv_np & 16'hBFFF)) ? pnp : pbase;
        if (p_cnt >= 3) word = word | 16'h4000;
        rx_cfg_valid = 1; rx_cfg = word; rx_idle = 0;
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pulse_restart();
    an_restart = 1; tick(); an_restart = 0;
  endtask

  task automatic wait_link(input int lim, output bit up, output bit saw_ack, output bit saw_np);
    up = 0; saw_ack = 0; saw_np = 0;
    for (int i = 0; i < lim && !up; i++) begin
      tick();
      if (tx_cfg_valid && tx_cfg[14]) saw_ack = 1;
      if (tx_cfg_valid && tx_cfg == adv_np) saw_np = 1;
      if (link_up) up = 1;
    end
  endtask

  task automatic wait_tx(input logic [15:0] w, input int lim, output int n);
    n = -1;
    for (int i = 0; i < lim && n < 0; i++) begin
      tick();
      if (tx_cfg_valid && tx_cfg == w) n = i;
    end
  endtask

  task automatic t_reset();
    chk(!tx_cfg_valid && tx_cfg == 0 && lp_base == 0 && lp_np == 0, "R1", "tx/lp after reset",
        {tx_cfg, 15'h0, tx_cfg_valid}, 0);
    chk(!link_up && !full_duplex && !tx_pause && !rx_pause && !an_fail, "R1", "status after reset",
        {link_up, full_duplex, tx_pause, rx_pause, an_fail}, 0);
  endtask

  task automatic t_basic();
    int n; bit up, sa, sn;
    an_en = 1;
    tick(); tick();
    chk(tx_cfg_valid && tx_cfg == 0, "R2", "zeros after enable", tx_cfg, 0);
    wait_tx(16'h01A0, 60, n);
    chk(n >= LT - 2 && n <= LT + 2, "R2", "zero run length", n, LT);
    chk(n >= 0, "R3", "base page masked", tx_cfg, 16'h01A0);
    wait_link(200, up, sa, sn);
    chk(up, "R5", "link up after exchange", link_up, 1);
    chk(sa, "R3", "ACK sent before link up", sa, 1);
    chk(!sn, "R6", "no next page when local NP clear", sn, 0);
    chk(lp_base == 16'h80A0, "R4", "partner base stored", lp_base, 16'h80A0);
    chk(full_duplex, "R7", "full duplex", full_duplex, 1);
    chk(tx_pause && rx_pause, "R8", "sym pause both", {tx_pause, rx_pause}, 2'b11);
  endtask

  task automatic t_cfg_in_link();
    bit up, sa, sn, dropped;
    ovr_valid = 1; ovr_word = 16'h00A0; ovr = 1;
    tick(); ovr = 0; ovr_valid = 0;
    dropped = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      if (!link_up && tx_cfg_valid && tx_cfg == 0) dropped = 1;
    end
    chk(dropped, "R9", "config word during link restarts", link_up, 0);
    wait_link(200, up, sa, sn);
    chk(up, "R9", "relink after restart", link_up, 1);
  endtask

  task automatic t_restart_bit();
    bit up, sa, sn;
    pulse_restart();
    chk(!link_up && tx_cfg_valid && tx_cfg == 0, "R2", "restart bit breaks link", tx_cfg, 0);
    wait_link(200, up, sa, sn);
    chk(up, "R2", "relink after restart bit", link_up, 1);
  endtask

  task automatic t_link_rst();
    bit up, sa, sn, bad;
    link_rst = 1; bad = 0;
    tick();
    for (int i = 0; i < 30; i++) begin
      tick();
      if (link_up || !tx_cfg_valid || tx_cfg != 0) bad = 1;
    end
    chk(!bad, "R12", "link reset holds break", link_up, 0);
    link_rst = 0;
    wait_link(200, up, sa, sn);
    chk(up, "R2", "relink after link reset falls", link_up, 1);
  endtask

  task automatic t_sync();
    bit up, sa, sn;
    sync_ok = 0;
    repeat (10) tick();
    chk(!link_up && tx_cfg_valid && tx_cfg == 0, "R12", "sync loss holds break", link_up, 0);
    sync_ok = 1;
    wait_link(200, up, sa, sn);
    chk(up, "R12", "relink after sync returns", link_up, 1);
  endtask

  task automatic t_break_word(input logic [15:0] w, input int len, input string req);
    int n; bit up, sa, sn, brk;
    pulse_restart();
    wait_tx(16'h41A0, 100, n);
    ovr_valid = 1; ovr_word = w; ovr = 1;
    brk = 0;
    for (int i = 0; i < len + 3; i++) begin
      if (i == len) begin ovr = 0; ovr_valid = 0; end
      tick();
      if (tx_cfg_valid && tx_cfg == 0) brk = 1;
    end
    ovr = 0; ovr_valid = 0;
    chk(n >= 0 && brk, req, "restart during acknowledge", {n[15:0], 15'h0, brk}, 1);
    wait_link(200, up, sa, sn);
    chk(up, req, "relink after break word", link_up, 1);
  endtask

  task automatic t_res(input logic [15:0] loc, input logic [15:0] prt,
                       input bit exp_up, input bit exp_fd, input bit exp_tx, input bit exp_rx,
                       input string req);
    bit up, sa, sn;
    adv_base = loc; pbase = prt;
    pulse_restart();
    if (exp_up) begin
      wait_link(200, up, sa, sn);
      chk(up && !an_fail, req, "link up", {up, an_fail}, 2'b10);
      chk(full_duplex == exp_fd, req, "duplex", full_duplex, exp_fd);
      chk(tx_pause == exp_tx && rx_pause == exp_rx, req, "pause",
          {tx_pause, rx_pause}, {exp_tx, exp_rx});
    end else begin
      for (int i = 0; i < 200 && !an_fail; i++) tick();
      chk(an_fail && !link_up, req, "no common duplex fails", {an_fail, link_up}, 2'b10);
    end
  endtask

  task automatic t_next_page();
    bit up, sa, sn;
    adv_base = 16'h81A0; pbase = 16'h80A0;
    pulse_restart();
    wait_link(300, up, sa, sn);
    chk(up && sn, "R6", "next page sent then link", {up, sn}, 2'b11);
    chk(lp_np == 16'h0555, "R6", "partner next page stored", lp_np, 16'h0555);
    chk(lp_base == 16'h80A0, "R4", "partner base kept", lp_base, 16'h80A0);
  endtask

  task automatic t_force();
    an_en = 0; force_link = 1; los = 1; rx_energy = 0;
    tick(); tick();
    chk(!link_up, "R13", "force blocked by LOS", link_up, 0);
    los = 0; tick(); tick();
    chk(link_up, "R13", "force up with signal", link_up, 1);
    los = 1; rx_energy = 1; tick(); tick();
    chk(link_up, "R13", "force up with energy", link_up, 1);
    force_link = 0; tick(); tick();
    chk(!link_up, "R13", "force released", link_up, 0);
    force_link = 1; an_en = 1; pbase = 16'h0; ovr = 1; ovr_valid = 0;
    tick(); tick();
    chk(!link_up, "R13", "force ignored with enable", link_up, 0);
    ovr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) tick();
    rst = 0;
    tick();
    t_reset();
    t_basic();
    t_cfg_in_link();
    t_restart_bit();
    t_link_rst();
    t_sync();
    t_break_word(16'h0000, 1, "R10");
    t_break_word(16'h0040, 6, "R11");
    t_res(16'h0060, 16'h0040, 1, 0, 0, 0, "R7");
    t_res(16'h0020, 16'h0040, 0, 0, 0, 0, "R7");
    t_res(16'h01A0, 16'h0120, 1, 1, 0, 1, "R8");
    t_res(16'h0120, 16'h01A0, 1, 1, 1, 0, "R8");
    t_res(16'h0120, 16'h0120, 1, 1, 0, 0, "R8");
    t_next_page();
    t_force();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule